// File: doc/BRIEF.md
# Battery Status Check Sequencer

This block is a small bus master that runs exactly once after each power-up reset. It sits on a byte-wide asynchronous memory port that has active-low chip select, output enable and write enable strobes. The attached battery-backed memory silently drops the first write after it powers up if its backup cell has run low. The sequencer uses that behaviour to test the cell.

After a recovery wait with every strobe held inactive, the sequencer reads one byte and keeps it. It then writes the inverted byte to the same location and reads that location again. If the second read returns the inverted byte, the write took effect and the cell is good. In that case the original byte is written back, so memory contents are unchanged. If the second read returns anything else, the cell is reported low, and the system should treat the stored data as suspect.

The result appears as a one-cycle completion pulse plus two flags that stay set. Both flags hold their value until the next power-up reset.

Top module: `bchk_seq`

## Requirements
- R1: While reset is asserted, mem_ce_n, mem_oe_n and mem_we_n are 1, and chk_done, batt_ok and batt_low are 0.
- R2: mem_ce_n stays 1 for at least RECOVERY_CYC clock cycles after reset is released.
- R3: Every access places CHECK_ADDR on mem_addr while mem_ce_n is 0.
- R4: For each access, mem_ce_n is 0 for exactly STROBE_CYC consecutive cycles. For a read, mem_rdata is sampled in the last of those cycles.
- R5: In a write access, mem_we_n is 0 in exactly the cycles where mem_ce_n is 0. mem_oe_n stays 1 and mem_drive is 1 whenever mem_we_n is 0. In a read access, mem_we_n stays 1 and mem_oe_n is 0.
- R6: The first access is a read. The second access is a write whose data is the bitwise inverse of the byte the first read returned.
- R7: The third access is a read of the same address.
- R8: If the third access returns the inverse of the first read, a fourth access writes the original byte back. After that, batt_ok is set and batt_low stays 0.
- R9: If the third access returns any other value, batt_low is set, batt_ok stays 0, and no fourth access occurs.
- R10: chk_done is 1 for exactly one cycle, in the cycle the flags first show the verdict. Afterwards the flags hold their value and no further access starts until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-up reset; releasing it starts one check |
| mem_addr | output | ADDR_W | Memory address, fixed at CHECK_ADDR |
| mem_wdata | output | DATA_W | Write data toward the memory |
| mem_rdata | input | DATA_W | Read data from the memory |
| mem_drive | output | 1 | High while the block drives write data on the bus |
| mem_ce_n | output | 1 | Active-low chip select |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| chk_done | output | 1 | One-cycle pulse when the verdict is reached |
| batt_ok | output | 1 | Sticky flag: the test write took effect |
| batt_low | output | 1 | Sticky flag: the test write was lost or corrupted |

## Verification
Faults in the sequence state show up on the bus strobes within a single access. A wrong access order, a missing restore, or an extra access after the verdict changes the count and kind of chip-select pulses the bench sees before chk_done.

A wrong saved byte or a wrong compare shows up as wrong write data on the second or fourth access, or as the wrong flag when chk_done fires. Either appears within a few tens of cycles after the recovery wait ends.

Faults in the strobe timing are visible on the first access. The bench catches a pulse of the wrong width, output enable overlapping a write, or the wait being cut short.

// File: rtl/bchk_pkg.sv
`timescale 1ns/1ps
package bchk_pkg;

    typedef enum logic [2:0] {
        ST_WAIT,
        ST_RD1,
        ST_WR_CPL,
        ST_RD2,
        ST_RESTORE,
        ST_HALT
    } seq_state_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SETUP,
        PH_STROBE,
        PH_HOLD
    } bus_phase_e;

endpackage

// File: rtl/bchk_recovery_timer.sv
`timescale 1ns/1ps
module bchk_recovery_timer #(
    parameter int CYCLES = 500000
) (
    input  logic clk,
    input  logic rst_n,
    output logic expired
);
    localparam int CNT_W = $clog2(CYCLES + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(CYCLES);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             done;
    } tmr_s;

    tmr_s tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (tmr_q.cnt != LIMIT) begin
            tmr_d.cnt = tmr_q.cnt + 1'b1;
        end
        tmr_d.done = (tmr_d.cnt == LIMIT);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign expired = tmr_q.done;

    AST_TIMER_STAYS_EXPIRED: assert property (@(posedge clk) disable iff (!rst_n)
        expired |=> expired) else $error("timer dropped"); // R2

endmodule

// File: rtl/bchk_bus_access.sv
`timescale 1ns/1ps
module bchk_bus_access
    import bchk_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int STROBE_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              is_write,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [DATA_W-1:0] rd_i,
    output logic              ack,
    output logic [DATA_W-1:0] rdata_o,
    output logic [DATA_W-1:0] wdata_o,
    output logic              drive,
    output logic              ce_n,
    output logic              oe_n,
    output logic              we_n
);
    localparam int CNT_W = $clog2(STROBE_CYC + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(STROBE_CYC - 1);

    typedef struct packed {
        bus_phase_e        phase;
        logic [CNT_W-1:0]  cnt;
        logic              wr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
        logic              ce_n;
        logic              oe_n;
        logic              we_n;
        logic              drive;
    } acc_s;

    localparam acc_s ACC_RST = '{
        phase: PH_IDLE, cnt: '0, wr: 1'b0, wdata: '0, rdata: '0,
        ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, drive: 1'b0
    };

    acc_s acc_d, acc_q;

    always_comb begin
        acc_d = acc_q;
        case (acc_q.phase)
            PH_IDLE: begin
                if (start) begin
                    acc_d.phase = PH_SETUP;
                    acc_d.wr    = is_write;
                    acc_d.wdata = wdata_i;
                    acc_d.cnt   = '0;
                end
            end
            PH_SETUP: begin
                acc_d.phase = PH_STROBE;
                acc_d.cnt   = '0;
            end
            PH_STROBE: begin
                if (acc_q.cnt == LAST) begin
                    if (!acc_q.wr) begin
                        acc_d.rdata = rd_i;
                    end
                    acc_d.phase = PH_HOLD;
                end else begin
                    acc_d.cnt = acc_q.cnt + 1'b1;
                end
            end
            PH_HOLD: begin
                acc_d.phase = PH_IDLE;
            end
            default: acc_d.phase = PH_IDLE;
        endcase
        // strobes are registered: decoded from the next phase
        acc_d.ce_n  = !(acc_d.phase == PH_STROBE);
        acc_d.we_n  = !((acc_d.phase == PH_STROBE) && acc_d.wr);
        acc_d.oe_n  = !((acc_d.phase == PH_STROBE) && !acc_d.wr);
        acc_d.drive = acc_d.wr && (acc_d.phase != PH_IDLE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= ACC_RST;
        end else begin
            acc_q <= acc_d;
        end
    end

    assign ack     = (acc_q.phase == PH_HOLD);
    assign rdata_o = acc_q.rdata;
    assign wdata_o = acc_q.wdata;
    assign drive   = acc_q.drive;
    assign ce_n    = acc_q.ce_n;
    assign oe_n    = acc_q.oe_n;
    assign we_n    = acc_q.we_n;

    AST_START_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> acc_q.phase == PH_IDLE) else $error("start while busy"); // R4
    AST_WE_INSIDE_CE: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> !ce_n) else $error("we without ce"); // R5
    AST_OE_OFF_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> (oe_n && drive)) else $error("oe during write"); // R5
    AST_STROBE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_q.phase == PH_STROBE && acc_q.cnt == LAST) |=> ce_n) else $error("strobe too long"); // R4

endmodule

// File: rtl/bchk_seq.sv
`timescale 1ns/1ps
module bchk_seq
    import bchk_pkg::*;
#(
    parameter int ADDR_W       = 11,
    parameter int DATA_W       = 8,
    parameter int CHECK_ADDR   = 0,
    parameter int RECOVERY_CYC = 500000,
    parameter int STROBE_CYC   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_drive,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic              chk_done,
    output logic              batt_ok,
    output logic              batt_low
);
    localparam logic [ADDR_W-1:0] ADDR_CONST = ADDR_W'(CHECK_ADDR);

    typedef struct packed {
        seq_state_e        state;
        logic              issued;
        logic [DATA_W-1:0] saved;
        logic              ok;
        logic              low;
        logic              done;
    } seq_s;

    seq_s seq_d, seq_q;

    logic              expired;
    logic              acc_start;
    logic              acc_write;
    logic [DATA_W-1:0] acc_wdata;
    logic              acc_ack;
    logic [DATA_W-1:0] acc_rdata;

    bchk_recovery_timer #(
        .CYCLES(RECOVERY_CYC)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .expired(expired)
    );

    bchk_bus_access #(
        .DATA_W    (DATA_W),
        .STROBE_CYC(STROBE_CYC)
    ) u_access (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (acc_start),
        .is_write(acc_write),
        .wdata_i (acc_wdata),
        .rd_i    (mem_rdata),
        .ack     (acc_ack),
        .rdata_o (acc_rdata),
        .wdata_o (mem_wdata),
        .drive   (mem_drive),
        .ce_n    (mem_ce_n),
        .oe_n    (mem_oe_n),
        .we_n    (mem_we_n)
    );

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        acc_start  = 1'b0;
        acc_write  = 1'b0;
        acc_wdata  = '0;
        case (seq_q.state)
            ST_WAIT: begin
                if (expired) begin
                    seq_d.state = ST_RD1;
                end
            end
            ST_RD1: begin
                acc_start = !seq_q.issued;
                if (acc_ack) begin
                    seq_d.saved = acc_rdata;
                    seq_d.state = ST_WR_CPL;
                end
            end
            ST_WR_CPL: begin
                acc_start = !seq_q.issued;
                acc_write = 1'b1;
                acc_wdata = ~seq_q.saved;
                if (acc_ack) begin
                    seq_d.state = ST_RD2;
                end
            end
            ST_RD2: begin
                acc_start = !seq_q.issued;
                if (acc_ack) begin
                    if (acc_rdata == ~seq_q.saved) begin
                        seq_d.state = ST_RESTORE;
                    end else begin
                        seq_d.low   = 1'b1;
                        seq_d.done  = 1'b1;
                        seq_d.state = ST_HALT;
                    end
                end
            end
            ST_RESTORE: begin
                acc_start = !seq_q.issued;
                acc_write = 1'b1;
                acc_wdata = seq_q.saved;
                if (acc_ack) begin
                    seq_d.ok    = 1'b1;
                    seq_d.done  = 1'b1;
                    seq_d.state = ST_HALT;
                end
            end
            ST_HALT: begin
            end
            default: seq_d.state = ST_HALT;
        endcase
        seq_d.issued = (seq_q.issued | acc_start) & !acc_ack;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{state: ST_WAIT, issued: 1'b0, saved: '0,
                       ok: 1'b0, low: 1'b0, done: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign mem_addr = ADDR_CONST;
    assign chk_done = seq_q.done;
    assign batt_ok  = seq_q.ok;
    assign batt_low = seq_q.low;

    AST_QUIET_DURING_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q.state == ST_WAIT |-> mem_ce_n) else $error("access in wait"); // R2
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        chk_done |=> !chk_done) else $error("done too long"); // R10
    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(batt_ok && batt_low)) else $error("both flags"); // R9
    AST_OK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        batt_ok |=> batt_ok) else $error("ok dropped"); // R8
    AST_LOW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        batt_low |=> batt_low) else $error("low dropped"); // R9
    AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q.state == ST_HALT |-> mem_ce_n) else $error("access after verdict"); // R10

endmodule

// File: tb/bchk_seq_tb.sv
`timescale 1ns/1ps
module bchk_seq_tb;
    localparam int ADDR_W = 11;
    localparam int DATA_W = 8;
    localparam int CADDR  = 'h2A5;
    localparam int RCYC   = 100;
    localparam int SCYC   = 3;
    localparam int M_GOOD = 0, M_DROP = 1, M_STUCK = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_wdata, mem_rdata;
    logic mem_drive, mem_ce_n, mem_oe_n, mem_we_n;
    logic chk_done, batt_ok, batt_low;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    logic [7:0] model_mem;
    bit         block_flag;
    int         mode;
    int         n_acc;
    int         since_rst;
    int         width;
    bit         acc_wr [0:7];
    logic [7:0] acc_data [0:7];
    logic       prev_ce, prev_we;
    logic [7:0] prev_wdata;

    always #2 clk = ~clk;

    bchk_seq #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CHECK_ADDR(CADDR),
        .RECOVERY_CYC(RCYC), .STROBE_CYC(SCYC)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_drive(mem_drive), .mem_ce_n(mem_ce_n),
        .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .chk_done(chk_done),
        .batt_ok(batt_ok), .batt_low(batt_low)
    );

    assign mem_rdata = (!mem_ce_n && !mem_oe_n) ? model_mem : 8'hA5;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int exp_nacc(input int m);
        return (m == M_GOOD) ? 4 : 3;
    endfunction

    function automatic logic [7:0] exp_final(input int m, input logic [7:0] orig);
        if (m == M_STUCK) return ~orig ^ 8'h01;
        return orig;
    endfunction

    // bus monitor and memory model, sampled on the falling edge
    always @(negedge clk) begin
        cycles++;
        if (!rst_n) begin
            n_acc = 0; since_rst = 0; width = 0;
            prev_ce = 1'b1; prev_we = 1'b1; prev_wdata = '0;
        end else begin
            since_rst++;
            if (prev_ce && !mem_ce_n) begin
                if (n_acc == 0) chk(since_rst >= RCYC, "R2 wait before first access", since_rst, RCYC);
                if (n_acc < 8) acc_wr[n_acc] = !mem_we_n;
                n_acc++;
                width = 0;
            end
            if (!mem_ce_n) begin
                width++;
                chk(mem_addr == ADDR_W'(CADDR), "R3 address", mem_addr, CADDR);
                chk(!mem_we_n == acc_wr[n_acc-1], "R5 we follows ce in write only", mem_we_n, !acc_wr[n_acc-1]);
                if (!mem_we_n) chk(mem_oe_n && mem_drive, "R5 oe high and drive on in write", {mem_oe_n, mem_drive}, 2'b11);
                else chk(!mem_oe_n, "R5 oe low in read", mem_oe_n, 0);
            end else begin
                chk(mem_we_n && mem_oe_n, "R5 strobes idle outside ce", {mem_we_n, mem_oe_n}, 2'b11);
            end
            if (!prev_ce && mem_ce_n) chk(width == SCYC, "R4 strobe width", width, SCYC);
            if (!prev_we && mem_we_n) begin
                if (n_acc <= 8) acc_data[n_acc-1] = prev_wdata;
                if (block_flag) block_flag = 1'b0;
                else if (mode == M_STUCK) model_mem = prev_wdata ^ 8'h01;
                else model_mem = prev_wdata;
            end
            prev_ce = mem_ce_n; prev_we = mem_we_n; prev_wdata = mem_wdata;
        end
    end

    initial begin
        while (cycles < 150000) @(negedge clk);
        chk(0, "watchdog", cycles, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    task automatic run_trial(input int m, input logic [7:0] orig);
        int n_seen;
        bit seen;
        mode = m;
        model_mem = orig;
        block_flag = (m == M_DROP);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(mem_ce_n && mem_oe_n && mem_we_n, "R1 strobes idle in reset", {mem_ce_n, mem_oe_n, mem_we_n}, 3'b111);
        chk(!chk_done && !batt_ok && !batt_low, "R1 outputs low in reset", {chk_done, batt_ok, batt_low}, 0);
        rst_n = 1'b1;
        seen = 0;
        for (int i = 0; i < 3000 && !seen; i++) begin
            @(negedge clk);
            if (chk_done) seen = 1;
        end
        chk(seen, "R10 done pulse", seen, 1);
        if (!seen) return;
        if (m == M_GOOD) chk(batt_ok && !batt_low, "R8 ok flag", {batt_ok, batt_low}, 2'b10);
        else chk(!batt_ok && batt_low, "R9 low flag", {batt_ok, batt_low}, 2'b01);
        chk(n_acc == exp_nacc(m), (m == M_GOOD) ? "R8 four accesses" : "R9 no restore access", n_acc, exp_nacc(m));
        chk(!acc_wr[0] && acc_wr[1], "R6 read then write", {acc_wr[0], acc_wr[1]}, 2'b01);
        chk(acc_data[1] == ~orig, "R6 complement written", acc_data[1], ~orig);
        chk(!acc_wr[2], "R7 third access is read", acc_wr[2], 0);
        if (m == M_GOOD) begin
            chk(acc_wr[3], "R8 fourth access is write", acc_wr[3], 1);
            chk(acc_data[3] == orig, "R8 original restored", acc_data[3], orig);
        end
        chk(model_mem == exp_final(m, orig), "R8 R9 final memory byte", model_mem, exp_final(m, orig));
        n_seen = n_acc;
        @(negedge clk);
        chk(!chk_done, "R10 done one cycle", chk_done, 0);
        repeat (40) @(negedge clk);
        chk(n_acc == n_seen, "R10 no access after verdict", n_acc, n_seen);
        chk(batt_ok == (m == M_GOOD) && batt_low == (m != M_GOOD), "R10 flags sticky",
            {batt_ok, batt_low}, (m == M_GOOD) ? 2'b10 : 2'b01);
    endtask

    initial begin
        void'($urandom(32'd2718));
        mode = M_GOOD; model_mem = '0; block_flag = 0;
        run_trial(M_GOOD, 8'h00);
        run_trial(M_GOOD, 8'hFF);
        run_trial(M_DROP, 8'h55);
        run_trial(M_STUCK, 8'hAA);
        run_trial(M_DROP, 8'h00);
        for (int t = 0; t < 16; t++) begin
            run_trial(int'($urandom % 3), 8'($urandom));
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule